// File: doc/BRIEF.md
# Transmit Descriptor DMA Run Control

This block sequences the transmit side of a descriptor-driven DMA engine. Software sets or clears a run bit and programs the base address of a descriptor ring. The block keeps a current descriptor pointer. It issues fetch requests for the descriptor at that pointer and inspects the owner flag that comes back. Based on that flag, it either holds in the running state until the frame completes, or parks in a suspended state with a sticky buffer-unavailable flag raised.

A stop request does not cut a frame short. The block finishes the frame in flight, then steps the pointer to the next descriptor and stops there. The next start resumes at that saved position. A new ring base address replaces it only if software wrote one while the run bit was clear.

The descriptor fetch request is a valid/ready handshake. Once the block raises `fetch_valid`, it holds the request and keeps `fetch_addr` unchanged until a cycle in which `fetch_ready` is high. Each accepted request must be answered by exactly one `desc_valid` pulse that carries the owner bit. The block is always able to take that pulse, so the response channel has no ready signal. The frame data path, the MAC and interrupt masking sit outside this block.

Top module: `txdma_run_ctrl`

## Requirements
- R1: After reset `run_state` is 0 (stopped), `fetch_addr` is 0, `status` bit 2 is 0 and `fetch_valid` is 0.
- R2: `run_state` encodes stopped as 0, running as 1 and suspended as 2. The value 3 never appears.
- R3: With the run bit set (write select 0, data bit 0 = 1) while stopped, the block enters running and requests the descriptor at the current position.
- R4: A fetched descriptor with the owner bit set keeps the block running until `frame_done`. On `frame_done` the pointer advances by `DESC_BYTES` and the next descriptor is requested.
- R5: A fetched descriptor with the owner bit clear moves the block to suspended and sets `status` bit 2 (buffer unavailable).
- R6: In suspended, a `poll_demand` pulse re-fetches the same descriptor. If that descriptor is now owned, the block returns to running. In suspended, `frame_done` changes neither the state nor the pointer.
- R7: Clearing the run bit while a frame is in progress leaves the block running until `frame_done`. It then stops with the pointer on the next descriptor.
- R8: Clearing the run bit while suspended stops the block within two cycles and leaves the pointer where it was.
- R9: A restart resumes at the position saved at the last stop, unless a new base address was accepted in between.
- R10: A base address write (select 1) is accepted only while the run bit is clear, and takes effect at the next start. While the run bit is set, such a write is ignored.
- R11: Status bit 2 is sticky. Writing select 2 with data bit 2 set clears it. Writing select 2 with data bit 2 clear has no effect.
- R12: While `fetch_valid` is high and `fetch_ready` is low, the next cycle keeps `fetch_valid` high and `fetch_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 run control, 1 ring base, 2 status clear |
| wr_data | input | ADDR_W | Write data |
| poll_demand | input | 1 | Re-check the current descriptor when suspended |
| frame_done | input | 1 | One-cycle pulse when the current frame has gone out |
| fetch_valid | output | 1 | Descriptor fetch request valid |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | ADDR_W | Current descriptor pointer / fetch address |
| desc_valid | input | 1 | Fetched descriptor response strobe |
| desc_owned | input | 1 | Owner bit of the fetched descriptor (1 = DMA owns) |
| run_state | output | 2 | 0 stopped, 1 running, 2 suspended |
| status | output | 8 | Raw status word, bit 2 buffer unavailable |

## Verification
The assertions assume that the descriptor source returns one `desc_valid` pulse per accepted request, and only after that request. They also assume that `frame_done` arrives only while a frame is in progress, except where the bench sends it on purpose to show it is ignored in suspended. The bench's responder answers each accepted fetch exactly one cycle after acceptance, from a small table of owner bits indexed by address. Inputs change only at the falling edge, so every handshake the properties reason about is well formed.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {
    RS_STOPPED   = 2'd0,
    RS_RUNNING   = 2'd1,
    RS_SUSPENDED = 2'd2
  } run_state_e;

  typedef enum logic [2:0] {
    F_IDLE, F_REQ, F_WAIT, F_XMIT, F_SUSP
  } fsm_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam int         BUF_UNAVAIL_BIT = 2;
  localparam int         STATUS_W = 8;
endpackage

// File: rtl/txdma_ptr.sv
module txdma_ptr #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              load,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_ptr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] base_q;
  logic              pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      pending_q <= 1'b1;
      cur_ptr   <= '0;
    end else begin
      if (base_wr) begin
        base_q    <= base_val;
        pending_q <= 1'b1;
      end
      if (load) begin
        if (pending_q) cur_ptr <= base_q;
        if (!base_wr) pending_q <= 1'b0;
      end else if (advance) begin
        cur_ptr <= cur_ptr + STEP;
      end
    end
  end
endmodule

// File: rtl/txdma_fsm.sv
module txdma_fsm
  import txdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_bit,
  input  logic       poll_demand,
  input  logic       frame_done,
  input  logic       fetch_ready,
  input  logic       desc_valid,
  input  logic       desc_owned,
  output logic       fetch_valid,
  output logic       load_ptr,
  output logic       adv_ptr,
  output logic       unavail_set,
  output logic [1:0] run_state
);
  fsm_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    load_ptr    = 1'b0;
    adv_ptr     = 1'b0;
    unavail_set = 1'b0;
    unique case (st_q)
      F_IDLE: if (run_bit) begin
        load_ptr = 1'b1;
        st_d     = F_REQ;
      end
      F_REQ:  if (fetch_ready) st_d = F_WAIT;
      F_WAIT: if (desc_valid) begin
        if (desc_owned) st_d = F_XMIT;
        else begin
          unavail_set = 1'b1;
          st_d        = F_SUSP;
        end
      end
      F_XMIT: if (frame_done) begin
        adv_ptr = 1'b1;
        st_d    = run_bit ? F_REQ : F_IDLE;
      end
      F_SUSP: begin
        if (!run_bit)        st_d = F_IDLE;
        else if (poll_demand) st_d = F_REQ;
      end
      default: st_d = F_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= F_IDLE;
    else        st_q <= st_d;
  end

  assign fetch_valid = (st_q == F_REQ);

  always_comb begin
    unique case (st_q)
      F_IDLE:  run_state = RS_STOPPED;
      F_SUSP:  run_state = RS_SUSPENDED;
      default: run_state = RS_RUNNING;
    endcase
  end
endmodule

// File: rtl/txdma_status.sv
module txdma_status
  import txdma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unavail_set,
  input  logic                unavail_clr,
  output logic [STATUS_W-1:0] status
);
  logic unavail_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           unavail_q <= 1'b0;
    else if (unavail_set) unavail_q <= 1'b1;
    else if (unavail_clr) unavail_q <= 1'b0;
  end

  always_comb begin
    status                  = '0;
    status[BUF_UNAVAIL_BIT] = unavail_q;
  end
endmodule

// File: rtl/txdma_run_ctrl.sv
module txdma_run_ctrl
  import txdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              poll_demand,
  input  logic              frame_done,
  output logic              fetch_valid,
  input  logic              fetch_ready,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              desc_valid,
  input  logic              desc_owned,
  output logic [1:0]        run_state,
  output logic [7:0]        status
);
  logic run_bit_q;
  logic load_ptr, adv_ptr, unavail_set;
  logic base_wr, unavail_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) run_bit_q <= 1'b0;
    else if (wr_en && wr_sel == SEL_CTRL) run_bit_q <= wr_data[0];
  end

  assign base_wr     = wr_en && (wr_sel == SEL_BASE) && !run_bit_q;
  assign unavail_clr = wr_en && (wr_sel == SEL_STAT) && wr_data[BUF_UNAVAIL_BIT];

  txdma_fsm u_fsm (
    .clk, .rst_n,
    .run_bit(run_bit_q), .poll_demand, .frame_done,
    .fetch_ready, .desc_valid, .desc_owned,
    .fetch_valid, .load_ptr, .adv_ptr, .unavail_set, .run_state
  );

  txdma_ptr #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk, .rst_n,
    .base_wr, .base_val(wr_data),
    .load(load_ptr), .advance(adv_ptr), .cur_ptr(fetch_addr)
  );

  txdma_status u_stat (
    .clk, .rst_n, .unavail_set, .unavail_clr, .status
  );
endmodule

// File: rtl/txdma_run_ctrl_chk.sv
module txdma_run_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_done,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [1:0]        run_state,
  input logic [7:0]        status
);
  // R2
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_state != 2'd3);

  // R12
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  // R7
  stop_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd0 && $past(run_state) == 2'd1) |-> $past(frame_done));

  // R5
  suspend_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd2 && $past(run_state) != 2'd2) |-> status[2]);

  // R6
  suspend_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd2 && $past(run_state) == 2'd2) |-> $stable(fetch_addr));

  // R1
  stopped_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd0) |-> !fetch_valid);
endmodule

bind txdma_run_ctrl txdma_run_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk, .rst_n, .frame_done, .fetch_valid, .fetch_ready,
  .fetch_addr, .run_state, .status
);

// File: tb/sim_txdma_run_ctrl.sv
module sim_txdma_run_ctrl;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [AW-1:0] wr_data = '0;
  logic          poll_demand = 1'b0;
  logic          frame_done = 1'b0;
  logic          fetch_valid;
  logic          fetch_ready = 1'b1;
  logic [AW-1:0] fetch_addr;
  logic          desc_valid = 1'b0;
  logic          desc_owned = 1'b0;
  logic [1:0]    run_state;
  logic [7:0]    status;
  logic [7:0]    own_tbl = 8'b0000_0011;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  txdma_run_ctrl #(.ADDR_W(AW), .DESC_BYTES(16)) u0 (.*);

  // descriptor source: one response a cycle after each accepted request
  always_ff @(posedge clk) begin
    desc_valid <= fetch_valid && fetch_ready;
    desc_owned <= own_tbl[fetch_addr[6:4]];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // op codes
  localparam logic [3:0] OP_CTL = 0, OP_BASE = 1, OP_STAT = 2,
                         OP_POLL = 3, OP_FRAME = 4, OP_OWN = 5;
  // {req[3:0], op[3:0], arg[31:0], state[1:0], addr[31:0], tu}
  localparam int NV = 22;
  localparam logic [74:0] VEC [NV] = '{
    {4'd10, OP_BASE,  32'h100, 2'd0, 32'h000, 1'b0}, // R10 pending only
    {4'd3,  OP_CTL,   32'h1,   2'd1, 32'h100, 1'b0}, // R3
    {4'd4,  OP_FRAME, 32'h0,   2'd1, 32'h110, 1'b0}, // R4
    {4'd5,  OP_FRAME, 32'h0,   2'd2, 32'h120, 1'b1}, // R5
    {4'd6,  OP_POLL,  32'h0,   2'd2, 32'h120, 1'b1}, // R6 still unowned
    {4'd11, OP_STAT,  32'h4,   2'd2, 32'h120, 1'b0}, // R11 clear
    {4'd6,  OP_OWN,   32'h2,   2'd2, 32'h120, 1'b0}, // R6 no poll yet
    {4'd6,  OP_POLL,  32'h0,   2'd1, 32'h120, 1'b0}, // R6 resume
    {4'd7,  OP_CTL,   32'h0,   2'd1, 32'h120, 1'b0}, // R7 deferred
    {4'd10, OP_BASE,  32'h200, 2'd1, 32'h120, 1'b0}, // R10 accepted, pending
    {4'd7,  OP_FRAME, 32'h0,   2'd0, 32'h130, 1'b0}, // R7 stop after frame
    {4'd10, OP_CTL,   32'h1,   2'd1, 32'h200, 1'b0}, // R10 new base used
    {4'd10, OP_BASE,  32'h300, 2'd1, 32'h200, 1'b0}, // R10 ignored
    {4'd4,  OP_FRAME, 32'h0,   2'd1, 32'h210, 1'b0}, // R4
    {4'd7,  OP_CTL,   32'h0,   2'd1, 32'h210, 1'b0}, // R7
    {4'd7,  OP_FRAME, 32'h0,   2'd0, 32'h220, 1'b0}, // R7
    {4'd9,  OP_CTL,   32'h1,   2'd1, 32'h220, 1'b0}, // R9 saved position
    {4'd5,  OP_FRAME, 32'h0,   2'd2, 32'h230, 1'b1}, // R5
    {4'd8,  OP_CTL,   32'h0,   2'd0, 32'h230, 1'b1}, // R8
    {4'd9,  OP_CTL,   32'h1,   2'd2, 32'h230, 1'b1}, // R9 resume, unowned
    {4'd11, OP_STAT,  32'h0,   2'd2, 32'h230, 1'b1}, // R11 zero write
    {4'd6,  OP_FRAME, 32'h0,   2'd2, 32'h230, 1'b1}  // R6 frame_done ignored
  };

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_op(input logic [3:0] op, input logic [31:0] arg);
    @(negedge clk);
    case (op)
      OP_CTL:   begin wr_en = 1; wr_sel = 2'd0; wr_data = arg; end
      OP_BASE:  begin wr_en = 1; wr_sel = 2'd1; wr_data = arg; end
      OP_STAT:  begin wr_en = 1; wr_sel = 2'd2; wr_data = arg; end
      OP_POLL:  poll_demand = 1;
      OP_FRAME: frame_done = 1;
      OP_OWN:   own_tbl[arg[2:0]] = 1'b1;
      default:  ;
    endcase
    @(negedge clk);
    wr_en = 0; poll_demand = 0; frame_done = 0;
  endtask

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(1, "state", 32'(run_state), 0);
    check(1, "addr", fetch_addr, 0);
    check(1, "tu", 32'(status[2]), 0);
    check(1, "fetch_valid", 32'(fetch_valid), 0);

    for (int v = 0; v < NV; v++) begin
      do_op(VEC[v][70:67], VEC[v][66:35]);
      idle(8);
      check(int'(VEC[v][74:71]), $sformatf("vec%0d state", v),
            32'(run_state), 32'(VEC[v][34:33]));
      check(int'(VEC[v][74:71]), $sformatf("vec%0d addr", v),
            fetch_addr, VEC[v][32:1]);
      check(int'(VEC[v][74:71]), $sformatf("vec%0d tu", v),
            32'(status[2]), 32'(VEC[v][0]));
    end

    // R12 back-pressure on fetch request
    do_op(OP_CTL, 32'h0);
    idle(4);
    check(8, "stopped before bp", 32'(run_state), 0);
    own_tbl[3] = 1'b1;
    fetch_ready = 1'b0;
    do_op(OP_CTL, 32'h1);
    idle(6);
    check(12, "valid held", 32'(fetch_valid), 1);
    check(12, "addr held", fetch_addr, 32'h230);
    check(2, "running while waiting", 32'(run_state), 1);
    fetch_ready = 1'b1;
    idle(6);
    check(12, "valid dropped", 32'(fetch_valid), 0);
    check(4, "owned after accept", 32'(run_state), 1);

    // R1 reset in mid-run
    rst_n = 0;
    idle(2);
    rst_n = 1;
    @(negedge clk);
    check(1, "state after reset", 32'(run_state), 0);
    check(1, "addr after reset", fetch_addr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule